// File: doc/BRIEF.md
# Microstepping Step-Table Indexer

This block converts a step-and-direction command stream into signed current set-points for the two windings of a bipolar stepper motor. It keeps a 5-bit position within one electrical revolution, split into 32 positions 11.25 degrees apart. Each new step command moves the position forward or backward by a stride that depends on the selected step resolution. Winding A receives the cosine of the electrical angle and winding B the sine. Both are given as signed whole percentages of full-scale current.

The step input is asynchronous to the block clock. It passes through a two-flop synchroniser, and a rising-edge detector then issues at most one advance per clock. Direction and resolution are sampled at the cycle of that advance. After reset the position is the 45-degree entry, where both windings carry +71 percent. An active-low flag marks this rest position. A one-cycle pulse marks every position change, so downstream current-regulation logic can compare the old and new set-points and tell whether each winding's magnitude rose or fell.

Top module: `stepidx_top`

## Requirements
- R1: While `rst` is high at a clock edge, the position becomes 4 (45 degrees), `cur_a_o` and `cur_b_o` both read +71, `home_n_o` reads 0 and `moved_o` reads 0.
- R2: Only a 0-to-1 transition of `step_in` causes a move. A falling edge causes none, and a high level held for many cycles causes only one.
- R3: The move size is set by `mode_in`: 2'b00 gives 8 positions, 2'b01 gives 4, 2'b10 gives 2 and 2'b11 gives 1.
- R4: When `dir_in` is 1 the position increases, and when it is 0 the position decreases.
- R5: The position wraps modulo 32 in both directions.
- R6: `cur_a_o` is round(100·cos(idx·11.25°)) in two's complement. Across 0 to 90 degrees the magnitudes are 100, 98, 92, 83, 71, 56, 38, 20 and 0. A positive value means terminal 1 of the winding is driven above terminal 2.
- R7: `cur_b_o` is round(100·sin(idx·11.25°)) in two's complement, which is winding A delayed by a quarter revolution.
- R8: `home_n_o` is 0 when the position is 4 and 1 at every other position.
- R9: Step edges that occur while `rst` is high are ignored. A `step_in` level that is still high when reset is released is not treated as a step.
- R10: A change of `mode_in` takes effect at the next step. The stride is added to the current position without first aligning it to the new resolution's grid.
- R11: `moved_o` is high for exactly one cycle per move. It rises at the third clock edge after the first edge that samples `step_in` high, the same edge at which the new position appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; returns the indexer to the 45-degree position |
| step_in | input | 1 | Asynchronous step command; each rising edge requests one move |
| dir_in | input | 1 | Direction: 1 = increasing angle, 0 = decreasing |
| mode_in | input | 2 | Resolution: 00 full, 01 half, 10 quarter, 11 eighth |
| idx_o | output | 5 | Current table position (angle = idx_o × 11.25°) |
| cur_a_o | output | 8 | Signed winding A set-point, percent of full scale |
| cur_b_o | output | 8 | Signed winding B set-point, percent of full scale |
| home_n_o | output | 1 | Low only at the 45-degree rest position |
| moved_o | output | 1 | One-cycle pulse with every position change |

## Verification
The hardest situation to reach is a step level that straddles reset. The synchroniser flops must come out of reset without creating a false edge. The bench first moves the position away from home. It then pulses `step_in` several times under reset and releases reset with `step_in` still high, and observes that neither the position nor the pulse output changes over the following cycles. Off-grid positions are reached by first taking one eighth-step and then switching to full-step, so the lack of realignment shows directly at the ports.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;

    localparam int IDX_W    = 5;
    localparam int CUR_W    = 8;
    localparam int POSITIONS = 1 << IDX_W;
    localparam int QUAD_POS  = POSITIONS / 4;
    localparam int MAG_W     = $clog2(QUAD_POS + 1);

    typedef logic [IDX_W-1:0]        idx_t;
    typedef logic signed [CUR_W-1:0] cur_t;
    typedef logic [MAG_W-1:0]        qoff_t;

    typedef enum logic [1:0] {
        RES_FULL    = 2'b00,
        RES_HALF    = 2'b01,
        RES_QUARTER = 2'b10,
        RES_EIGHTH  = 2'b11
    } res_e;

    typedef struct packed {
        cur_t coil_a;
        cur_t coil_b;
    } coil_pair_t;

    // magnitude of cos at k quarter-table steps (k = 0..8)
    function automatic cur_t quad_mag(qoff_t k);
        case (k)
            qoff_t'(0): return cur_t'(100);
            qoff_t'(1): return cur_t'(98);
            qoff_t'(2): return cur_t'(92);
            qoff_t'(3): return cur_t'(83);
            qoff_t'(4): return cur_t'(71);
            qoff_t'(5): return cur_t'(56);
            qoff_t'(6): return cur_t'(38);
            qoff_t'(7): return cur_t'(20);
            default:    return cur_t'(0);
        endcase
    endfunction

    function automatic cur_t cos_code(idx_t i);
        logic [1:0] quad;
        qoff_t      near_k;
        qoff_t      far_k;
        quad   = i[IDX_W-1 -: 2];
        near_k = qoff_t'(i[IDX_W-3:0]);
        far_k  = qoff_t'(QUAD_POS) - near_k;
        case (quad)
            2'd0:    return  quad_mag(near_k);
            2'd1:    return -quad_mag(far_k);
            2'd2:    return -quad_mag(near_k);
            default: return  quad_mag(far_k);
        endcase
    endfunction

    function automatic idx_t stride_of(res_e r);
        case (r)
            RES_FULL:    return idx_t'(QUAD_POS);
            RES_HALF:    return idx_t'(QUAD_POS / 2);
            RES_QUARTER: return idx_t'(QUAD_POS / 4);
            default:     return idx_t'(QUAD_POS / 8);
        endcase
    endfunction

endpackage

// File: rtl/stepidx_edge.sv
module stepidx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // reset to ones: a level already high at release is not an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stepidx_pos.sv
module stepidx_pos
    import stepidx_pkg::*;
#(
    parameter int HOME_IDX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic dir_up,
    input  res_e res,
    output idx_t idx,
    output logic moved
);
    idx_t step_sz;
    idx_t idx_next;

    always_comb begin
        step_sz  = stride_of(res);
        idx_next = dir_up ? (idx + step_sz) : (idx - step_sz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= idx_t'(HOME_IDX);
            moved <= 1'b0;
        end else begin
            moved <= advance;
            if (advance) idx <= idx_next;
        end
    end
endmodule

// File: rtl/stepidx_lut.sv
module stepidx_lut
    import stepidx_pkg::*;
(
    input  idx_t       idx,
    output coil_pair_t pair
);
    idx_t idx_lag;

    always_comb begin
        idx_lag     = idx - idx_t'(QUAD_POS);
        pair.coil_a = cos_code(idx);
        pair.coil_b = cos_code(idx_lag);
    end
endmodule

// File: rtl/stepidx_top.sv
module stepidx_top
    import stepidx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOME_IDX    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [1:0]       mode_in,
    output logic [IDX_W-1:0] idx_o,
    output logic signed [CUR_W-1:0] cur_a_o,
    output logic signed [CUR_W-1:0] cur_b_o,
    output logic             home_n_o,
    output logic             moved_o
);
    logic       step_rise;
    idx_t       pos;
    coil_pair_t pair;

    stepidx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (step_in),
        .rise (step_rise)
    );

    stepidx_pos #(.HOME_IDX(HOME_IDX)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .advance (step_rise),
        .dir_up  (dir_in),
        .res     (res_e'(mode_in)),
        .idx     (pos),
        .moved   (moved_o)
    );

    stepidx_lut u_lut (
        .idx  (pos),
        .pair (pair)
    );

    assign idx_o    = pos;
    assign cur_a_o  = pair.coil_a;
    assign cur_b_o  = pair.coil_b;
    assign home_n_o = (pos != idx_t'(HOME_IDX));
endmodule

// File: rtl/stepidx_chk.sv
module stepidx_chk
    import stepidx_pkg::*;
#(
    parameter int HOME_IDX = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             dir_in,
    input logic [1:0]       mode_in,
    input logic [IDX_W-1:0] idx_o,
    input logic signed [CUR_W-1:0] cur_a_o,
    input logic signed [CUR_W-1:0] cur_b_o,
    input logic             home_n_o,
    input logic             moved_o
);
    // R1: reset returns to the rest position with no pulse
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (idx_o == IDX_W'(HOME_IDX)) && !moved_o);

    // R3, R4, R5: each move is one stride in the sampled direction
    p_stride_r3: assert property (@(posedge clk) disable iff (rst)
        (moved_o && !$past(rst)) |->
        (idx_o == ($past(dir_in)
            ? IDX_W'($past(idx_o) + (IDX_W'(1) << (2'd3 - $past(mode_in))))
            : IDX_W'($past(idx_o) - (IDX_W'(1) << (2'd3 - $past(mode_in)))))));

    // R2: without a pulse the position holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!moved_o && !$past(rst)) |-> $stable(idx_o));

    // R8, R6, R7: rest flag low implies both windings at +71
    p_home_codes_r8: assert property (@(posedge clk) disable iff (rst)
        !home_n_o |-> (cur_a_o == 8'sd71) && (cur_b_o == 8'sd71));

    // R11: the move pulse lasts a single cycle
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        moved_o |=> !moved_o);

    // R9: no move while reset is held
    p_no_move_in_reset_r9: assert property (@(posedge clk)
        rst |=> !moved_o);
endmodule

bind stepidx_top stepidx_chk #(.HOME_IDX(HOME_IDX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_in   (dir_in),
    .mode_in  (mode_in),
    .idx_o    (idx_o),
    .cur_a_o  (cur_a_o),
    .cur_b_o  (cur_b_o),
    .home_n_o (home_n_o),
    .moved_o  (moved_o)
);

// File: tb/tb_stepidx_top.sv
module tb_stepidx_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOME = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_in = 1'b1;
    logic [1:0] mode_in = 2'b11;
    logic [4:0] idx_o;
    logic signed [7:0] cur_a_o;
    logic signed [7:0] cur_b_o;
    logic       home_n_o;
    logic       moved_o;

    int checks = 0;
    int errors = 0;
    int exp_idx = HOME;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepidx_top dut (
        .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
        .mode_in(mode_in), .idx_o(idx_o), .cur_a_o(cur_a_o),
        .cur_b_o(cur_b_o), .home_n_o(home_n_o), .moved_o(moved_o)
    );

    function automatic int round_pct(real v);
        if (v >= 0.0) return $rtoi(100.0 * v + 0.5);
        return -$rtoi(-100.0 * v + 0.5);
    endfunction

    function automatic int ref_a(int i);
        return round_pct($cos(i * 11.25 * 3.14159265358979 / 180.0));
    endfunction

    function automatic int ref_b(int i);
        return round_pct($sin(i * 11.25 * 3.14159265358979 / 180.0));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " idx"}, int'(idx_o), exp_idx);
        chk({req, " R6 coil A"}, int'(cur_a_o), ref_a(exp_idx));
        chk({req, " R7 coil B"}, int'(cur_b_o), ref_b(exp_idx));
        chk({req, " R8 home flag"}, int'(home_n_o), (exp_idx == HOME) ? 0 : 1);
    endtask

    // one step: R11 timing, R3/R4/R5 position, then release
    task automatic do_step(input bit d, input logic [1:0] m, input string req);
        int stride;
        @(negedge clk);
        dir_in = d;
        mode_in = m;
        step_in = 1'b1;
        stride = 8 >> m;
        exp_idx = d ? (exp_idx + stride) % 32 : (exp_idx + 32 - stride) % 32;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({req, " R11 no early pulse"}, int'(moved_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk({req, " R11 pulse"}, int'(moved_o), 1);
        chk_outputs(req);
        @(posedge clk);
        @(negedge clk);
        chk({req, " R11 pulse width"}, int'(moved_o), 0);
        step_in = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk_outputs("R1 reset");
        chk("R1 moved in reset", int'(moved_o), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_outputs("R1 after release");
    endtask

    task automatic t_eighth_walk;
        for (int k = 0; k < 32; k++) do_step(1'b1, 2'b11, "R3 R4 R5 eighth fwd");
        chk("R5 full loop home", int'(idx_o), HOME);
    endtask

    task automatic t_reverse;
        for (int k = 0; k < 4; k++) do_step(1'b0, 2'b10, "R4 R5 quarter rev");
        for (int k = 0; k < 3; k++) do_step(1'b0, 2'b01, "R3 half rev");
    endtask

    task automatic t_full;
        for (int k = 0; k < 5; k++) do_step(1'b1, 2'b00, "R3 R5 full fwd");
    endtask

    task automatic t_realign;
        do_step(1'b1, 2'b11, "R10 eighth");
        do_step(1'b1, 2'b00, "R10 full off-grid");
        do_step(1'b0, 2'b01, "R10 half off-grid");
    endtask

    task automatic t_held;
        int pulses = 0;
        int start_idx;
        @(negedge clk);
        start_idx = exp_idx;
        dir_in = 1'b1;
        mode_in = 2'b11;
        step_in = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (moved_o) pulses++;
        end
        chk("R2 held high one pulse", pulses, 1);
        exp_idx = (start_idx + 1) % 32;
        chk_outputs("R2 held high");
        pulses = 0;
        step_in = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (moved_o) pulses++;
        end
        chk("R2 falling edge no move", pulses, 0);
        chk_outputs("R2 after fall");
    endtask

    task automatic t_reset_ignore;
        int pulses = 0;
        do_step(1'b1, 2'b10, "R9 setup");
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) step_in = 1'b1;
            @(negedge clk) step_in = 1'b0;
        end
        @(negedge clk) step_in = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_idx = HOME;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (moved_o) pulses++;
        end
        chk("R9 no move across reset", pulses, 0);
        chk_outputs("R9 R1 after reset");
        step_in = 1'b0;
        repeat (4) @(posedge clk);
        do_step(1'b1, 2'b11, "R9 next step works");
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_eighth_walk();
        t_reverse();
        t_full();
        t_realign();
        t_held();
        t_reset_ignore();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule